// File: doc/BRIEF.md
# Peak Current-Mode Cycle Timer

This block times the gate-on interval of each switching cycle in a fixed-frequency converter that uses peak current-mode control. An oscillator pulse starts each cycle and switches the gate request on. The pulse then ends on the first comparator trip that arrives after a leading-edge blanking window, or on a hard maximum-duty clamp, whichever is earlier. The analog comparators, the slope generator and the oscillator sit outside the block. The block only sees their digital flags and the period length in clock ticks.

The same 40%-of-period point serves three purposes. It enables slope compensation while the pulse continues. It latches the selection of the long-duty current-limit curve for the cycle. It is also the instant at which the current-sense level is checked for a shorted sense resistor. Three consecutive pulses that reach this point with the sense level still below the short threshold raise a fault. A hold input stops switching at once.

Top module: `pcm_cycle_timer`

## Requirements
- R1: When `cyc_start` is sampled high at a clock edge and `hold` is low, the gate request is high after that edge and the on-time count restarts at 0. This applies even if a pulse is already running.
- R2: Trips on `pwm_trip` and `ilim_trip` are ignored while the on-time count t is below BLANK = floor(BLANK_NS*1000/CLK_PS), which is 44 by default. A pulse whose trip is held high from the start therefore lasts BLANK+1 ticks.
- R3: An edge that samples either trip with t >= BLANK ends the pulse, so the gate is high for t+1 ticks.
- R4: With no trip, the gate stays high for exactly T75 = floor(3*period/4) ticks.
- R5: `slope_en` is high exactly while the gate is high and t >= T40 = floor(2*period/5).
- R6: `curve_sel` goes to 1 at the edge after t first reaches T40 during a pulse. It stays at that value until the next cycle start or until hold, both of which clear it.
- R7: At the edge where a pulse has t == T40, `cs_low` is sampled. A high sample adds one to a consecutive count and a low sample clears the count. Pulses that end before T40 leave the count as it was. When the count reaches 3, `cs_short_flt` is set.
- R8: `cs_short_flt` is sticky and is cleared only by reset. Neither `hold` nor later good pulses clear it.
- R9: `hold` forces the gate low in the same cycle without waiting for a clock edge. It clears the pulse state, and after `hold` falls the gate stays low until the next cycle start.
- R10: During reset, all four outputs are 0.
- R11: T40 and T75 follow the `period` input, with fractions truncated. For example, a period of 203 gives a maximum on-time of 152.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold | input | 1 | Disable: gate low at once, pulse state cleared |
| cyc_start | input | 1 | Oscillator cycle-start pulse |
| pwm_trip | input | 1 | PWM comparator trip flag |
| ilim_trip | input | 1 | Current-limit comparator trip flag |
| cs_low | input | 1 | Current sense below the short threshold |
| period | input | CNT_W | Switching period in ticks |
| gate | output | 1 | Gate request |
| slope_en | output | 1 | Slope-compensation enable |
| curve_sel | output | 1 | Long-duty current-limit curve select |
| cs_short_flt | output | 1 | Sense-short fault |

## Verification
The sense-short sample and the comparator turn-off can land on the same edge. This happens when a trip is raised exactly at t == T40. The bench provokes this case and expects the sample to count toward the fault even though the gate falls on that same edge. A cycle start that arrives in the middle of a pulse also coincides with an on-time update. In that case the restart must win while the previous pulse's curve flag is cleared. A behavioural model is compared against the design on every clock, and targeted on-time measurements judge the blanking, clamp and truncation limits.

// File: rtl/pcm_cycle_timer.sv
module pcm_cycle_timer #(
  parameter int CNT_W      = 16,
  parameter int CLK_PS     = 5000,
  parameter int BLANK_NS   = 220,
  parameter int SHORT_HITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             cyc_start,
  input  logic             pwm_trip,
  input  logic             ilim_trip,
  input  logic             cs_low,
  input  logic [CNT_W-1:0] period,
  output logic             gate,
  output logic             slope_en,
  output logic             curve_sel,
  output logic             cs_short_flt
);
  localparam int BLANK = (BLANK_NS * 1000) / CLK_PS;
  localparam int SC_W  = $clog2(SHORT_HITS + 1);

  logic [CNT_W+1:0] p_ext, t40_w, t75_w;
  logic [CNT_W-1:0] t40, t75, t;
  logic             gate_r, curve_r, flt_r;
  logic [SC_W-1:0]  sc;

  assign p_ext = {2'b00, period};
  assign t40_w = (p_ext << 1) / (CNT_W+2)'(5);
  assign t75_w = (p_ext + (p_ext << 1)) >> 2;
  assign t40   = t40_w[CNT_W-1:0];
  assign t75   = t75_w[CNT_W-1:0];

  wire trip    = pwm_trip | ilim_trip;
  wire unblank = t >= CNT_W'(BLANK);
  wire at_max  = ({1'b0, t} + (CNT_W+1)'(1)) >= {1'b0, t75};
  wire stop    = (trip & unblank) | at_max;
  wire past40  = t >= t40;
  wire at_smp  = gate_r & (t == t40);

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      gate_r  <= 1'b0;
      t       <= '0;
      curve_r <= 1'b0;
    end else if (cyc_start) begin
      gate_r  <= 1'b1;
      t       <= '0;
      curve_r <= 1'b0;
    end else if (gate_r) begin
      curve_r <= curve_r | past40;
      if (stop) gate_r <= 1'b0;
      else      t      <= t + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc    <= '0;
      flt_r <= 1'b0;
    end else if (!hold && at_smp) begin
      if (cs_low) begin
        if (sc != SC_W'(SHORT_HITS)) sc <= sc + 1'b1;
        if (sc >= SC_W'(SHORT_HITS - 1)) flt_r <= 1'b1;
      end else begin
        sc <= '0;
      end
    end
  end

  assign gate         = gate_r & ~hold;
  assign slope_en     = gate & past40;
  assign curve_sel    = curve_r;
  assign cs_short_flt = flt_r;

  // R1
  start_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start && !hold |=> gate_r);

  // R2
  blank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_r && !hold && !cyc_start && !unblank && !at_max |=> gate_r);

  // R6
  curve_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slope_en && !cyc_start |=> curve_sel);

  // R7
  flt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_short_flt) |-> $past(at_smp && cs_low));

  // R8
  flt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_short_flt |=> cs_short_flt);

  // R9
  hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !gate_r && !curve_sel);
endmodule

// File: tb/pcm_cycle_timer_tb_top.sv
`timescale 1ns/1ps
module pcm_cycle_timer_tb_top;
  logic clk = 0, rst_n = 0, hold = 0, cyc_start = 0, pwm_trip = 0, ilim_trip = 0, cs_low = 0;
  logic [15:0] period = 16'd400;
  logic gate, slope_en, curve_sel, cs_short_flt;
  int nchk = 0, nfail = 0, ot;
  int mg = 0, mt = 0, mcv = 0, msc = 0, mflt = 0;

  pcm_cycle_timer dut_i (.clk(clk), .rst_n(rst_n), .hold(hold), .cyc_start(cyc_start),
    .pwm_trip(pwm_trip), .ilim_trip(ilim_trip), .cs_low(cs_low), .period(period),
    .gate(gate), .slope_en(slope_en), .curve_sel(curve_sel), .cs_short_flt(cs_short_flt));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model: from the requirements, integer state
  always @(posedge clk) begin
    int d40, d75;
    d40 = (2 * int'(period)) / 5;
    d75 = (3 * int'(period)) / 4;
    if (!rst_n) begin
      mg = 0; mt = 0; mcv = 0; msc = 0; mflt = 0;
    end else if (hold) begin
      mg = 0; mt = 0; mcv = 0;
    end else begin
      if (mg && mt == d40) begin
        if (cs_low) begin
          msc = (msc < 3) ? msc + 1 : 3;
          if (msc == 3) mflt = 1;
        end else msc = 0;
      end
      if (cyc_start) begin
        mg = 1; mt = 0; mcv = 0;
      end else if (mg) begin
        if (mt >= d40) mcv = 1;
        if (((pwm_trip || ilim_trip) && mt >= 44) || mt + 1 >= d75) mg = 0;
        else mt = mt + 1;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    chk("R3", "gate", int'(gate), int'(mg != 0 && !hold));
    chk("R5", "slope_en", int'(slope_en), int'(mg != 0 && !hold && mt >= (2 * int'(period)) / 5));
    chk("R6", "curve_sel", int'(curve_sel), mcv);
    chk("R7", "cs_short_flt", int'(cs_short_flt), mflt);
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R10", "gate in reset", int'(gate), 0);
    chk("R10", "slope in reset", int'(slope_en), 0);
    chk("R10", "curve in reset", int'(curve_sel), 0);
    chk("R10", "flt in reset", int'(cs_short_flt), 0);
    rst_n = 1;
  endtask

  task automatic pulse(input int trip_at, input bit csl, input bit use_ilim, output int ontime);
    @(negedge clk); cyc_start = 1; cs_low = csl;
    @(negedge clk); cyc_start = 0; ontime = 0;
    while (gate) begin
      if (ontime >= trip_at) begin
        if (use_ilim) ilim_trip = 1; else pwm_trip = 1;
      end
      ontime++;
      @(negedge clk);
    end
    pwm_trip = 0; ilim_trip = 0; cs_low = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    do_reset();
    pulse(100, 0, 0, ot); chk("R3", "pwm trip on-time", ot, 101);
    chk("R6", "curve after short pulse", int'(curve_sel), 0);
    pulse(100, 0, 1, ot); chk("R3", "ilim trip on-time", ot, 101);
    pulse(0, 0, 0, ot);   chk("R2", "blanked on-time", ot, 45);
    pulse(1000, 0, 0, ot); chk("R4", "max duty on-time", ot, 300);
    chk("R6", "curve after long pulse", int'(curve_sel), 1);
    chk("R5", "slope off after pulse", int'(slope_en), 0);
    period = 16'd203;
    pulse(1000, 0, 0, ot); chk("R11", "truncated max duty", ot, 152);
    period = 16'd400;

    // hold mid-pulse
    @(negedge clk); cyc_start = 1; @(negedge clk); cyc_start = 0;
    repeat (20) @(negedge clk);
    hold = 1; #0.5; chk("R9", "gate under hold", int'(gate), 0);
    @(negedge clk); hold = 0;
    repeat (5) @(negedge clk);
    chk("R9", "gate after hold", int'(gate), 0);

    // restart during a pulse
    @(negedge clk); cyc_start = 1; @(negedge clk); cyc_start = 0;
    repeat (30) @(negedge clk);
    cyc_start = 1; @(negedge clk); cyc_start = 0;
    chk("R1", "gate after restart", int'(gate), 1);
    while (gate) @(negedge clk);
    chk("R6", "curve after restarted pulse", int'(curve_sel), 1);

    // short pulses leave the count alone
    do_reset();
    pulse(1000, 1, 0, ot); pulse(1000, 1, 0, ot);
    pulse(50, 0, 0, ot);
    chk("R7", "flt after two lows", int'(cs_short_flt), 0);
    pulse(1000, 1, 0, ot);
    chk("R7", "flt when short pulse skipped", int'(cs_short_flt), 1);

    // good sample clears, same-edge sample and trip counts
    do_reset();
    pulse(1000, 1, 0, ot); pulse(1000, 1, 0, ot);
    pulse(1000, 0, 0, ot);
    pulse(1000, 1, 0, ot); pulse(1000, 1, 0, ot);
    chk("R7", "flt after clear then two lows", int'(cs_short_flt), 0);
    pulse(160, 1, 0, ot);
    chk("R3", "trip at sample point on-time", ot, 161);
    chk("R7", "flt with trip at sample edge", int'(cs_short_flt), 1);
    pulse(1000, 0, 0, ot);
    @(negedge clk); hold = 1; @(negedge clk); hold = 0;
    chk("R8", "flt sticky", int'(cs_short_flt), 1);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule